// File: doc/BRIEF.md
# Per-Object Chained Packet Slot Manager

This block manages a store of packet slots. Every slot carries one packet word and one link pointer. The packets of each object form a singly linked chain. The chain starts at the newest packet (the tail) and runs back toward the first packet, whose link is null. Slots that hold no packet sit on their own chain, the free list, which is entered through the free pointer.

An external index owns each object's tail pointer and packet count. It sends one command at a time:

- **Append** places a packet in the slot at the free-list head and links it behind the given tail.
- **Drop** removes the tail packet and returns the new tail.
- **Release** walks an object's whole chain and hands every slot back to the free list.
- **Fetch** walks back from the tail to reach packet p of an object whose newest packet is number n.

The slot store is an internal array with one slot access per cycle. Append and drop therefore cost one access. Release costs one access per stored packet, and fetch costs n-p link steps plus one read.

Commands arrive on a valid/ready port. `req_ready` is high only while no command is in progress. A command is accepted on the clock edge where `req_valid` and `req_ready` are both high. The requester holds its fields stable until that edge. Valid is ignored while ready is low, so that is the only back-pressure. Each result appears as a one-cycle `done` pulse that the requester cannot stall.

Top module: `chain_store`

## Requirements
- R1: After reset:
  - every slot is free and `store_full` is low;
  - `req_ready` is high and `done` is low;
  - slot i links to slot i+1, so appends from reset use slots 0, 1, 2 ... in order.
- R2: An accepted append (`req_op`=0) writes its data into the free-list head slot and links it to `req_tail` (null = SLOTS starts a new object). `done` rises one cycle after acceptance, with `done_slot` set to the slot used.
- R3: `store_full` is high exactly when no slot is free. An append accepted while full returns `done_err`=1 one cycle later and leaves the free list unchanged.
- R4: An accepted drop (`req_op`=1) of a non-null tail returns that tail's link as `done_slot` one cycle after acceptance. The freed slot becomes the free-list head, so the next append reuses it.
- R5: An accepted release (`req_op`=2) of a chain of n packets pushes each slot onto the free-list head, newest first. `done` rises n+1 cycles after acceptance with `done_count`=n. A null tail gives `done_count`=0 after one cycle.
- R6: An accepted fetch (`req_op`=3) with `req_pos` <= `req_last` returns the data and slot of packet `req_pos` n-p+2 cycles after acceptance, where n=`req_last` and p=`req_pos`. A fetch leaves the free list unchanged.
- R7: A fetch with a null tail or with `req_pos` > `req_last` returns `done_err`=1 one cycle after acceptance.
- R8: `req_ready` stays low from the acceptance of a release or fetch until its `done` pulse. A `req_valid` asserted during that time produces no result and changes no slot.
- R9: A drop with a null tail returns `done_err`=1 one cycle after acceptance and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Block idle, command can be accepted |
| req_op | input | 2 | 0 append, 1 drop, 2 release, 3 fetch |
| req_tail | input | $clog2(SLOTS+1) | Object tail slot, SLOTS means null |
| req_last | input | $clog2(SLOTS+1) | Packet number of the tail (fetch) |
| req_pos | input | $clog2(SLOTS+1) | Packet number wanted (fetch) |
| req_data | input | DATA_W | Packet word to append |
| done | output | 1 | One-cycle result pulse |
| done_err | output | 1 | Command could not be carried out |
| done_slot | output | $clog2(SLOTS+1) | Appended slot, new tail, or fetched slot |
| done_data | output | DATA_W | Fetched packet word |
| done_count | output | $clog2(SLOTS+1) | Slots freed by a release |
| store_full | output | 1 | Free list empty |

## Verification
Each result has a fixed due time counted from the accepting edge:

| Command | Cycles until `done` |
|---|---|
| Append, drop, and every error case | 1 |
| Release of n packets | n+1 |
| Fetch | n-p+2 |

The driver notes the cycle number when it presents a command and stores the due cycle in the scoreboard entry. The monitor samples on falling edges and checks that every `done` pulse arrives exactly on its due cycle. It also checks that no pulse arrives with an empty scoreboard, which is how commands ignored while busy are caught. The scoreboard holds the expected slot numbers, which come from the bench's own free-list model.

// File: rtl/chain_store_pkg.sv
package chain_store_pkg;
  typedef enum logic [1:0] {
    OP_APPEND  = 2'd0,
    OP_DROP    = 2'd1,
    OP_RELEASE = 2'd2,
    OP_FETCH   = 2'd3
  } chain_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FREE = 2'd1,
    ST_WALK = 2'd2
  } chain_st_e;
endpackage

// File: rtl/chain_slot_ram.sv
module chain_slot_ram #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     addr,
  output logic [PW-1:0]     rd_link,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_link_en,
  input  logic [PW-1:0]     wr_link,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  localparam logic [PW-1:0] NULLP = PW'(SLOTS);

  logic [PW-1:0]     link_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  // one storage cell per slot; reset chains slot i to slot i+1
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    assign hit = (addr == PW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        link_q[i] <= PW'(i + 1);
        data_q[i] <= '0;
      end else begin
        if (wr_link_en && hit) link_q[i] <= wr_link;
        if (wr_data_en && hit) data_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_link = NULLP;
    rd_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (addr == PW'(i)) begin
        rd_link = link_q[i];
        rd_data = data_q[i];
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_link_en || wr_data_en) |-> (addr < NULLP)); // R2
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_store_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PW-1:0]     req_tail,
  input  logic [PW-1:0]     req_last,
  input  logic [PW-1:0]     req_pos,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              done_err,
  output logic [PW-1:0]     done_slot,
  output logic [DATA_W-1:0] done_data,
  output logic [PW-1:0]     done_count,
  output logic              store_full,
  output logic [PW-1:0]     ram_addr,
  input  logic [PW-1:0]     ram_link,
  input  logic [DATA_W-1:0] ram_data,
  output logic              ram_wl_en,
  output logic [PW-1:0]     ram_wl,
  output logic              ram_wd_en,
  output logic [DATA_W-1:0] ram_wd
);
  localparam logic [PW-1:0] NULLP = PW'(SLOTS);

  chain_op_e         op;
  chain_st_e         state_q, state_d;
  logic [PW-1:0]     free_q, free_d, cur_q, cur_d, steps_q, steps_d, cnt_q, cnt_d;
  logic              done_d, err_d;
  logic [PW-1:0]     slot_d, count_d;
  logic [DATA_W-1:0] data_d;
  logic              accept;

  assign op         = chain_op_e'(req_op);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign store_full = (free_q == NULLP);
  assign ram_wd     = req_data;

  always_comb begin
    state_d   = state_q;
    free_d    = free_q;
    cur_d     = cur_q;
    steps_d   = steps_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    slot_d    = NULLP;
    data_d    = done_data;
    count_d   = done_count;
    ram_addr  = cur_q;
    ram_wl_en = 1'b0;
    ram_wl    = free_q;
    ram_wd_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_APPEND: begin
              done_d = 1'b1;
              if (free_q == NULLP) begin
                err_d = 1'b1;
              end else begin
                ram_addr  = free_q;
                ram_wl_en = 1'b1;
                ram_wl    = req_tail;
                ram_wd_en = 1'b1;
                free_d    = ram_link;
                slot_d    = free_q;
              end
            end
            OP_DROP: begin
              done_d = 1'b1;
              if (req_tail == NULLP) begin
                err_d = 1'b1;
              end else begin
                ram_addr  = req_tail;
                ram_wl_en = 1'b1;
                ram_wl    = free_q;
                free_d    = req_tail;
                slot_d    = ram_link;
              end
            end
            OP_RELEASE: begin
              if (req_tail == NULLP) begin
                done_d  = 1'b1;
                count_d = '0;
              end else begin
                state_d = ST_FREE;
                cur_d   = req_tail;
                cnt_d   = '0;
              end
            end
            default: begin
              if (req_tail == NULLP || req_pos > req_last) begin
                done_d = 1'b1;
                err_d  = 1'b1;
              end else begin
                state_d = ST_WALK;
                cur_d   = req_tail;
                steps_d = req_last - req_pos;
              end
            end
          endcase
        end
      end
      ST_FREE: begin
        ram_addr  = cur_q;
        ram_wl_en = 1'b1;
        ram_wl    = free_q;
        free_d    = cur_q;
        cnt_d     = cnt_q + 1'b1;
        if (ram_link == NULLP) begin
          done_d  = 1'b1;
          count_d = cnt_q + 1'b1;
          state_d = ST_IDLE;
        end else begin
          cur_d = ram_link;
        end
      end
      default: begin
        ram_addr = cur_q;
        if (cur_q == NULLP) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (steps_q == '0) begin
          done_d  = 1'b1;
          slot_d  = cur_q;
          data_d  = ram_data;
          state_d = ST_IDLE;
        end else begin
          cur_d   = ram_link;
          steps_d = steps_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      free_q     <= '0;
      cur_q      <= NULLP;
      steps_q    <= '0;
      cnt_q      <= '0;
      done       <= 1'b0;
      done_err   <= 1'b0;
      done_slot  <= NULLP;
      done_data  <= '0;
      done_count <= '0;
    end else begin
      state_q    <= state_d;
      free_q     <= free_d;
      cur_q      <= cur_d;
      steps_q    <= steps_d;
      cnt_q      <= cnt_d;
      done       <= done_d;
      done_err   <= err_d;
      done_slot  <= slot_d;
      done_data  <= data_d;
      done_count <= count_d;
    end
  end

  AST_SHORT_OP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_APPEND || op == OP_DROP)) |=> done); // R2
  AST_FULL_APPEND_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_APPEND && store_full) |=> (done_err && free_q == $past(free_q))); // R3
  AST_DROP_FREES_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_DROP && req_tail != NULLP) |=> (free_q == $past(req_tail))); // R4
  AST_FETCH_KEEPS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WALK) |=> (free_q == $past(free_q))); // R6
  AST_FETCH_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FETCH && (req_tail == NULLP || req_pos > req_last)) |=> (done && done_err)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_RELEASE || op == OP_FETCH) && req_tail != NULLP && req_pos <= req_last)
      |=> !req_ready); // R8
endmodule

// File: rtl/chain_store.sv
module chain_store #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PW-1:0]     req_tail,
  input  logic [PW-1:0]     req_last,
  input  logic [PW-1:0]     req_pos,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              done_err,
  output logic [PW-1:0]     done_slot,
  output logic [DATA_W-1:0] done_data,
  output logic [PW-1:0]     done_count,
  output logic              store_full
);
  logic [PW-1:0]     ram_addr, ram_link, ram_wl;
  logic [DATA_W-1:0] ram_data, ram_wd;
  logic              ram_wl_en, ram_wd_en;

  chain_ctrl #(.SLOTS(SLOTS), .DATA_W(DATA_W)) ctrl_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_tail, .req_last,
    .req_pos, .req_data, .done, .done_err, .done_slot, .done_data,
    .done_count, .store_full,
    .ram_addr, .ram_link, .ram_data, .ram_wl_en, .ram_wl, .ram_wd_en, .ram_wd
  );

  chain_slot_ram #(.SLOTS(SLOTS), .DATA_W(DATA_W)) ram_i (
    .clk, .rst_n, .addr(ram_addr), .rd_link(ram_link), .rd_data(ram_data),
    .wr_link_en(ram_wl_en), .wr_link(ram_wl), .wr_data_en(ram_wd_en),
    .wr_data(ram_wd)
  );
endmodule

// File: tb/chain_store_tb_top.sv
`timescale 1ns/1ps
module chain_store_tb_top;
  localparam int NS = 16;
  localparam int DW = 16;
  localparam int PW = $clog2(NS + 1);
  localparam int NUL = NS;

  typedef struct {
    int    due;
    int    op;
    bit    err;
    int    slot;
    int    data;
    int    cnt;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [PW-1:0] req_tail = '0, req_last = '0, req_pos = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, done_err, store_full;
  logic [PW-1:0] done_slot, done_count;
  logic [DW-1:0] done_data;

  chain_store #(.SLOTS(NS), .DATA_W(DW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_tail, .req_last,
    .req_pos, .req_data, .done, .done_err, .done_slot, .done_data,
    .done_count, .store_full
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  exp_t sb[$];
  int freeq[$];
  int mlink[NS];
  int mdata[NS];
  int otail[4];
  int olen[4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: computes expected result from the bench model, queues it, drives the request
  task automatic issue(input int op, input int o, input int pos, input int d, input string tag);
    exp_t e;
    int t, steps, lat;
    t = otail[o];
    e.op = op; e.err = 0; e.slot = NUL; e.data = 0; e.cnt = 0; e.tag = tag;
    lat = 1;
    case (op)
      0: if (freeq.size() == 0) e.err = 1;
         else begin
           e.slot = freeq.pop_front();
           mlink[e.slot] = t; mdata[e.slot] = d;
           otail[o] = e.slot; olen[o]++;
         end
      1: if (t == NUL) e.err = 1;
         else begin
           e.slot = mlink[t]; freeq.push_front(t);
           otail[o] = e.slot; olen[o]--;
         end
      2: begin
           while (t != NUL) begin
             int nx;
             nx = mlink[t]; freeq.push_front(t); e.cnt++; t = nx;
           end
           lat = (e.cnt == 0) ? 1 : e.cnt + 1;
           otail[o] = NUL; olen[o] = 0;
         end
      default: if (t == NUL || pos > olen[o]) e.err = 1;
         else begin
           steps = olen[o] - pos;
           for (int k = 0; k < steps; k++) t = mlink[t];
           e.slot = t; e.data = mdata[t]; lat = steps + 2;
         end
    endcase
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_tail = otail_prev(o, op, t, e);
    req_last = PW'(olen_req(o, op)); req_pos = PW'(pos); req_data = DW'(d);
    e.due = cyc + lat;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // request fields saved before the model update
  int pend_tail, pend_len;
  function automatic logic [PW-1:0] otail_prev(input int o, input int op, input int t, input exp_t e);
    return PW'(pend_tail);
  endfunction
  function automatic int olen_req(input int o, input int op);
    return pend_len;
  endfunction

  task automatic cmd(input int op, input int o, input int pos, input int d, input string tag);
    pend_tail = otail[o]; pend_len = olen[o];
    issue(op, o, pos, d, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected results as done pulses arrive
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, {e.tag, " due cycle"}, cyc, e.due);
        chk(done_err == e.err, {e.tag, " err"}, int'(done_err), int'(e.err));
        if (!e.err && e.op != 2) chk(int'(done_slot) == e.slot, {e.tag, " slot"}, int'(done_slot), e.slot);
        if (!e.err && e.op == 3) chk(int'(done_data) == e.data, {e.tag, " data"}, int'(done_data), e.data);
        if (e.op == 2) chk(int'(done_count) == e.cnt, {e.tag, " count"}, int'(done_count), e.cnt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin freeq.push_back(i); mlink[i] = i + 1; mdata[i] = 0; end
    for (int o = 0; o < 4; o++) begin otail[o] = NUL; olen[o] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(store_full == 1'b0, "R1 not full after reset", int'(store_full), 0);
    chk(done == 1'b0, "R1 no done after reset", int'(done), 0);

    for (int i = 1; i <= 5; i++) cmd(0, 0, 0, 16'h100 + i, "R1 R2 append obj0");
    for (int i = 1; i <= 3; i++) cmd(0, 1, 0, 16'h200 + i, "R2 append obj1");
    cmd(3, 0, 1, 0, "R6 fetch first");
    cmd(3, 0, 5, 0, "R6 fetch tail");
    cmd(3, 0, 3, 0, "R6 fetch middle");
    cmd(3, 0, 6, 0, "R7 fetch beyond last");
    cmd(3, 3, 1, 0, "R7 fetch null tail");
    cmd(1, 0, 0, 0, "R4 drop tail");
    cmd(0, 1, 0, 16'h2AA, "R4 reuse dropped slot");
    cmd(1, 3, 0, 0, "R9 drop null tail");
    cmd(0, 3, 0, 16'h3A0, "R9 append after null drop");
    cmd(2, 0, 0, 0, "R5 release obj0");
    cmd(2, 2, 0, 0, "R5 release empty");
    drain();

    // R8: valid held while a release walks is ignored
    pend_tail = otail[1]; pend_len = olen[1];
    fork
      issue(2, 1, 0, 0, "R5 R8 release obj1");
      begin
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b0, "R8 busy not ready", int'(req_ready), 0);
        req_valid = 1'b1; req_op = 2'd0; req_tail = PW'(NUL); req_data = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    drain();
    cmd(0, 2, 0, 16'h500, "R8 R2 append after ignored");

    while (freeq.size() != 0) cmd(0, 2, 0, 16'h500 + olen[2], "R3 fill");
    drain();
    chk(store_full == 1'b1, "R3 full flag", int'(store_full), 1);
    cmd(0, 3, 0, 16'h777, "R3 append when full");
    cmd(3, 2, 1, 0, "R6 deep fetch");
    drain();
    chk(store_full == 1'b1, "R3 full unchanged", int'(store_full), 1);
    cmd(1, 2, 0, 0, "R4 drop frees one");
    drain();
    chk(store_full == 1'b0, "R3 R4 not full after drop", int'(store_full), 0);
    cmd(2, 2, 0, 0, "R5 release large");
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule